// File: doc/BRIEF.md
# Configurable External Interrupt Sensitivity Unit

This block turns three ports of synchronized input pins into two external interrupt requests. One routing input decides how the pin groups are shared. Port A always feeds source 0 and port B always feeds source 1. Port C joins source 0 when the routing input is 0 and joins source 1 when it is 1. Each pin also has an enable bit, and a pin whose enable is clear does not take part in detection.

Each source has a 2-bit sensitivity field held in a register. The field picks one of four trigger conditions. The two falling-edge conditions and the low-level condition look at the AND of the enabled pins. The rising-edge condition looks at the OR of the enabled pins. Edges are found by comparing this cycle's combined value with a registered copy taken one cycle earlier.

The sensitivity fields can only be written while the global interrupt mask is set, so software must mask interrupts before it changes them. A reset, a change of the routing input or a change of a sensitivity field gives the comparison registers a fresh sample. Such a change therefore never looks like a pin edge.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset is released, both sensitivity fields read 00. `irq_o` is 0 during reset and after the first rising clock edge.
- R2: When `route_sel_i`=0, source 0 combines the enabled pins of `pa_i` and `pc_i`, and source 1 combines the enabled pins of `pb_i` only.
- R3: When `route_sel_i`=1, source 0 combines the enabled pins of `pa_i` only, and source 1 combines the enabled pins of `pb_i` and `pc_i`.
- R4: For each source, the "low" signal is the AND of its enabled pins, and the "high" signal is the OR of its enabled pins. Requests are registered: `irq_o[s]` after a clock edge reflects the inputs sampled at that edge, compared with the inputs sampled at the edge before. Mode 00 (falling edge plus low level) asserts `irq_o[s]` at every edge where the low signal is 0.
- R5: Mode 01 (rising edge) asserts `irq_o[s]` for one cycle when the high signal goes from 0 to 1 between two consecutive samples.
- R6: Mode 10 (falling edge) asserts `irq_o[s]` for one cycle when the low signal goes from 1 to 0 between two consecutive samples.
- R7: Mode 11 (both edges) asserts `irq_o[s]` for one cycle on either the R5 event or the R6 event.
- R8: A write is the pair `sens_wr_i`=1 and `irq_mask_i`=1 at a clock edge. It loads `sens0_i` into field 0 (source 0) and `sens1_i` into field 1 (source 1). The new modes apply from the next edge.
- R9: A write attempt made while `irq_mask_i`=0 leaves both fields unchanged.
- R10: No request is asserted at an edge where one of these holds: it is the first edge after reset, `route_sel_i` differs from its value at the previous edge, or an accepted write changes a field. The comparison registers still take the new sample at that edge.
- R11: A pin whose enable bit is 0 counts as 1 in the low signal and as 0 in the high signal. With no pin enabled, a source never requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pa_i | input | PA_W | Port A pins (synchronized) |
| pb_i | input | PB_W | Port B pins (synchronized) |
| pc_i | input | PC_W | Port C pins (synchronized) |
| pa_en_i | input | PA_W | Port A per-pin enables |
| pb_en_i | input | PB_W | Port B per-pin enables |
| pc_en_i | input | PC_W | Port C per-pin enables |
| route_sel_i | input | 1 | Port C routing: 0 to source 0, 1 to source 1 |
| sens_wr_i | input | 1 | Sensitivity write strobe |
| sens0_i | input | 2 | New sensitivity for source 0 |
| sens1_i | input | 2 | New sensitivity for source 1 |
| irq_mask_i | input | 1 | Global interrupt mask; writes accepted only when 1 |
| irq_o | output | 2 | Request per source (bit 0 = source 0) |

## Verification
The bench builds the block with its default widths: 8 pins on ports A and B and 6 pins on port C. With these widths a random word often drives the AND of a whole group low and the OR of a group high, so all four modes fire often. The bench also turns off pins one at a time through the enables. With only 22 pins in total, the bench can toggle the routing input in the middle of traffic and steer a single port C pin between the two sources. This checks that a routing change never produces a request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned NUM_SRC = 2;

  typedef enum logic [1:0] {
    SENS_FALL_LOW = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } sens_mode_e;
endpackage

// File: rtl/ext_irq_route.sv
module ext_irq_route #(
  parameter int unsigned PA_W = 8,
  parameter int unsigned PB_W = 8,
  parameter int unsigned PC_W = 6
) (
  input  logic [PA_W-1:0] pa_i,
  input  logic [PB_W-1:0] pb_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PA_W-1:0] pa_en_i,
  input  logic [PB_W-1:0] pb_en_i,
  input  logic [PC_W-1:0] pc_en_i,
  input  logic            route_sel_i,
  output logic [1:0]      all_hi_o,
  output logic [1:0]      any_hi_o
);
  logic a_all, b_all, c_all, a_any, b_any, c_any;

  // disabled pins read 1 for the AND, 0 for the OR
  assign a_all = &(pa_i | ~pa_en_i);
  assign b_all = &(pb_i | ~pb_en_i);
  assign c_all = &(pc_i | ~pc_en_i);
  assign a_any = |(pa_i & pa_en_i);
  assign b_any = |(pb_i & pb_en_i);
  assign c_any = |(pc_i & pc_en_i);

  always_comb begin
    all_hi_o[0] = a_all & (route_sel_i | c_all);
    any_hi_o[0] = a_any | (~route_sel_i & c_any);
    all_hi_o[1] = b_all & (~route_sel_i | c_all);
    any_hi_o[1] = b_any | (route_sel_i & c_any);
  end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       all_hi_i,
  input  logic       any_hi_i,
  input  logic [1:0] mode_i,
  input  logic       hold_i,
  output logic       irq_o
);
  logic prev_all_q, prev_any_q, irq_q;
  logic fall, rise, hit;

  assign fall = prev_all_q & ~all_hi_i;
  assign rise = ~prev_any_q & any_hi_i;

  always_comb begin
    unique case (sens_mode_e'(mode_i))
      SENS_FALL_LOW: hit = ~all_hi_i;
      SENS_RISE:     hit = rise;
      SENS_FALL:     hit = fall;
      default:       hit = rise | fall;
    endcase
  end

  // history always tracks the live value; hold only masks the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_all_q <= 1'b1;
      prev_any_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      prev_all_q <= all_hi_i;
      prev_any_q <= any_hi_i;
      irq_q      <= hit & ~hold_i;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned PA_W = 8,
  parameter int unsigned PB_W = 8,
  parameter int unsigned PC_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PA_W-1:0] pa_i,
  input  logic [PB_W-1:0] pb_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PA_W-1:0] pa_en_i,
  input  logic [PB_W-1:0] pb_en_i,
  input  logic [PC_W-1:0] pc_en_i,
  input  logic            route_sel_i,
  input  logic            sens_wr_i,
  input  logic [1:0]      sens0_i,
  input  logic [1:0]      sens1_i,
  input  logic            irq_mask_i,
  output logic [1:0]      irq_o
);
  logic [NUM_SRC-1:0][1:0] sens_q, sens_d;
  logic                    route_q, primed_q;
  logic                    wr_ok, hold;
  logic [1:0]              all_hi, any_hi;

  assign sens_d = {sens1_i, sens0_i};
  assign wr_ok  = sens_wr_i & irq_mask_i;
  assign hold   = ~primed_q | (route_sel_i != route_q) | (wr_ok & (sens_d != sens_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sens_q   <= '0;
      route_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      route_q  <= route_sel_i;
      primed_q <= 1'b1;
      if (wr_ok) sens_q <= sens_d;
    end
  end

  ext_irq_route #(.PA_W(PA_W), .PB_W(PB_W), .PC_W(PC_W)) u_route (
    .pa_i, .pb_i, .pc_i, .pa_en_i, .pb_en_i, .pc_en_i, .route_sel_i,
    .all_hi_o (all_hi),
    .any_hi_o (any_hi)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    ext_irq_detect u_det (
      .clk_i,
      .rst_ni,
      .all_hi_i (all_hi[s]),
      .any_hi_i (any_hi[s]),
      .mode_i   (sens_q[s]),
      .hold_i   (hold),
      .irq_o    (irq_o[s])
    );
  end
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sens_wr_i,
  input logic       irq_mask_i,
  input logic [1:0] sens0_i,
  input logic [1:0] sens1_i,
  input logic       route_sel_i,
  input logic       route_q,
  input logic       primed_q,
  input logic [3:0] sens_q,
  input logic [1:0] irq_o
);
  // R1
  first_edge_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_q |=> irq_o == 2'b00);

  // R8
  masked_write_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sens_wr_i && irq_mask_i) |=> sens_q == $past({sens1_i, sens0_i}));

  // R9
  unmasked_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sens_wr_i && !irq_mask_i) |=> $stable(sens_q));

  // R10
  route_change_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed_q && route_sel_i != route_q) |=> irq_o == 2'b00);

  // R6
  fall_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] && sens_q[1:0] == 2'b10) |=> !irq_o[0]);

  // R5
  rise_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[1] && sens_q[3:2] == 2'b01) |=> !irq_o[1]);
endmodule

bind ext_irq_sense ext_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sens_wr_i   (sens_wr_i),
  .irq_mask_i  (irq_mask_i),
  .sens0_i     (sens0_i),
  .sens1_i     (sens1_i),
  .route_sel_i (route_sel_i),
  .route_q     (route_q),
  .primed_q    (primed_q),
  .sens_q      (sens_q),
  .irq_o       (irq_o)
);

// File: tb/sim_ext_irq_sense.sv
`timescale 1ns/1ps
module sim_ext_irq_sense;
  localparam int PA_W = 8, PB_W = 8, PC_W = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [PA_W-1:0] pa, pa_en;
  logic [PB_W-1:0] pb, pb_en;
  logic [PC_W-1:0] pc, pc_en;
  logic route, wr, mask;
  logic [1:0] s0, s1, irq;

  int checks = 0, errors = 0;
  string tag = "";

  // reference state
  logic [1:0] m_sens [2];
  logic m_route, m_primed;
  logic m_pall [2];
  logic m_pany [2];
  logic [1:0] m_irq;

  always #2.5 clk = ~clk;

  ext_irq_sense #(.PA_W(PA_W), .PB_W(PB_W), .PC_W(PC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pa_i(pa), .pb_i(pb), .pc_i(pc),
    .pa_en_i(pa_en), .pb_en_i(pb_en), .pc_en_i(pc_en),
    .route_sel_i(route), .sens_wr_i(wr), .sens0_i(s0), .sens1_i(s1),
    .irq_mask_i(mask), .irq_o(irq)
  );

  function automatic logic grp_all(logic [7:0] v, logic [7:0] e);
    return &(v | ~e);
  endfunction
  function automatic logic grp_any(logic [7:0] v, logic [7:0] e);
    return |(v & e);
  endfunction

  task automatic model_reset();
    m_sens[0] = 2'b00; m_sens[1] = 2'b00;
    m_route = 1'b0; m_primed = 1'b0;
    m_pall[0] = 1'b1; m_pall[1] = 1'b1;
    m_pany[0] = 1'b0; m_pany[1] = 1'b0;
    m_irq = 2'b00;
  endtask

  task automatic model_edge();
    logic al [2];
    logic an [2];
    logic a_al, b_al, c_al, a_an, b_an, c_an, hold, hit, wok;
    a_al = grp_all(pa, pa_en); b_al = grp_all(pb, pb_en); c_al = grp_all({2'b11, pc}, {2'b00, pc_en});
    a_an = grp_any(pa, pa_en); b_an = grp_any(pb, pb_en); c_an = grp_any({2'b00, pc}, {2'b00, pc_en});
    // R2 / R3 routing of port C
    al[0] = route ? a_al : (a_al & c_al);
    an[0] = route ? a_an : (a_an | c_an);
    al[1] = route ? (b_al & c_al) : b_al;
    an[1] = route ? (b_an | c_an) : b_an;
    wok  = wr && mask;
    hold = !m_primed || (route != m_route) || (wok && ({s1, s0} != {m_sens[1], m_sens[0]}));
    for (int s = 0; s < 2; s++) begin
      case (m_sens[s])
        2'b00:   hit = !al[s];
        2'b01:   hit = !m_pany[s] && an[s];
        2'b10:   hit = m_pall[s] && !al[s];
        default: hit = (!m_pany[s] && an[s]) || (m_pall[s] && !al[s]);
      endcase
      m_irq[s] = hit && !hold;
      m_pall[s] = al[s];
      m_pany[s] = an[s];
    end
    m_route = route; m_primed = 1'b1;
    if (wok) begin m_sens[0] = s0; m_sens[1] = s1; end
  endtask

  function automatic string mode_tag(int s, logic hold_now);
    if (tag != "") return tag;
    case (m_sens[s])
      2'b00: return "R4";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    for (int s = 0; s < 2; s++) begin
      checks++;
      if (irq[s] !== m_irq[s]) begin
        errors++;
        $display("FAIL %s: irq_o[%0d] actual %b expected %b at %0t", mode_tag(s, 1'b0), s, irq[s], m_irq[s], $time);
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1 compare();
    @(negedge clk);
  endtask

  task automatic write_sens(logic [1:0] a, logic [1:0] b, logic mk);
    s0 = a; s1 = b; mask = mk; wr = 1'b1;
    step();
    wr = 1'b0; mask = 1'b1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7719);
    pa = '1; pb = '1; pc = '1; pa_en = '1; pb_en = '1; pc_en = '1;
    route = 1'b0; wr = 1'b0; mask = 1'b1; s0 = 2'b00; s1 = 2'b00;
    model_reset();
    repeat (3) @(negedge clk);
    tag = "R1";
    checks++;
    if (irq !== 2'b00) begin
      errors++;
      $display("FAIL R1: irq_o in reset actual %b expected 00", irq);
    end
    rst_ni = 1'b1;
    pa = 8'h00; // low on first edge must still be quiet
    step();
    pa = '1;
    step(); step();

    // R2: mode 00 default, port C on source 0
    tag = "R2";
    pc[2] = 1'b0; step(); step(); pc = '1; step();
    // R10: route flip while port C low
    tag = "R10";
    pc[0] = 1'b0; step(); route = 1'b1; step();
    // R3: port C now on source 1
    tag = "R3";
    step(); pc = '1; step(); pc[5] = 1'b0; step(); pc = '1; step();

    // R11: disabled pins ignored
    tag = "R11";
    pc_en = '0; pc = '0; step(); step();
    pa_en = 8'hFE; pa = 8'hFE; step();
    pa_en = '0; pb_en = '0; pb = '0; step(); step();
    pa_en = '1; pb_en = '1; pc_en = '1; pa = '1; pb = '1; pc = '1; step(); step();

    // R8: masked write to rising mode, then rise
    tag = "R8";
    write_sens(2'b01, 2'b01, 1'b1);
    pa = '0; pb = '0; pc = '0; step();
    tag = "R5";
    pa[3] = 1'b1; step(); step();
    // R9: unmasked write to falling is ignored
    tag = "R9";
    write_sens(2'b10, 2'b10, 1'b0);
    pa = '0; step(); pa[6] = 1'b1; step(); step();
    // R6 / R7 directed
    tag = "R6";
    write_sens(2'b10, 2'b11, 1'b1);
    pa = '1; pb = '1; pc = '1; step(); pa[1] = 1'b0; step(); step();
    tag = "R7";
    pb[4] = 1'b0; step(); pb = '1; step(); step();
    tag = "R10";
    write_sens(2'b00, 2'b00, 1'b1);
    tag = "";

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      pa = (r[3:0] < 4) ? 8'($urandom) : ((r[4]) ? '1 : '0);
      pb = (r[7:5] < 3) ? 8'($urandom) : ((r[8]) ? '1 : '0);
      pc = (r[11:9] < 3) ? 6'($urandom) : ((r[12]) ? '1 : '0);
      if (r[17:13] == 0) begin pa_en = 8'($urandom); pb_en = 8'($urandom); pc_en = 6'($urandom); end
      else if (r[17:13] == 1) begin pa_en = '1; pb_en = '1; pc_en = '1; end
      if (r[22:18] == 0) route = ~route;
      wr = (r[26:23] == 0);
      mask = r[27] | r[28];
      s0 = 2'($urandom); s1 = 2'($urandom);
      step();
    end
    wr = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule